// File: doc/BRIEF.md
# Interval Timer Host Register Front End

This block sits between an 8-bit host bus and three counting channels of an interval timer. It decodes the host's chip select, read strobe, write strobe and two-bit address. It accepts control words that set each channel's counting mode, number format and byte access style. It steers count bytes to the addressed channel and assembles them into 16-bit load values. For each channel it tracks whether the next read or write uses the low byte or the high byte. The counting engines are outside the block. Each channel's running count comes in on a live-count input.

The bus is synchronous to `clk`. A write takes place on every rising edge where `cs_n` and `wr_n` are both low. A read takes place on every rising edge where `cs_n` and `rd_n` are low and `wr_n` is high. A read advances the byte sequencing, and `rdata` always shows the byte that a read of the addressed location would return. Each channel also has a snapshot register. A latch command freezes the live count in it, so the host can read a consistent 16-bit value over two accesses while the channel keeps counting.

Top module: `tmr_host_if`

## Requirements
- R1: Address 0, 1 and 2 select channels 0, 1 and 2. Address 3 selects the control word register. A read of address 3 returns 0x00.
- R2: An edge with `cs_n` high does nothing: no pulse, no state change. When `rd_n` and `wr_n` are both low, the edge is a write only.
- R3: A control word has the channel in bits 7:6, the access code in bits 5:4, the mode in bits 3:1 and BCD in bit 0. When the access code is not 00, the channel's `ch_mode` and `ch_bcd` take the new values one cycle after the write, and `ch_mode_set` pulses for that channel for one cycle. A control word with bits 7:6 = 11 is ignored.
- R4: Access code 01 (low byte only): each count write loads {0x00, byte}. The load is shown as a one-cycle `ch_load` pulse with `ch_load_val`, one cycle after the write.
- R5: Access code 10 (high byte only): each count write loads {byte, 0x00}.
- R6: Access code 11 (low then high): the first write stores the low byte and causes no load. The second write loads {second, first}.
- R7: Reads with access 01 return the low byte and reads with access 10 return the high byte. With access 11, reads alternate low, high, low, and so on, starting with the low byte.
- R8: A control word with access code 00 is a latch command. It copies the channel's live count into the snapshot and pulses `ch_latch_req` one cycle later. Reads then return the snapshot until it has been fully read: one read for access 01 or 10, two reads for access 11. After that, reads return the live count again.
- R9: While a snapshot has not been fully read, further latch commands to that channel are ignored: no pulse, and the snapshot is unchanged.
- R10: Reads never produce a load, mode-set or latch pulse, and never change `ch_load_val`.
- R11: A control word with a nonzero access code does three things to its channel. It returns the read and write byte pointers to the low byte, it discards a half-written count, and it drops any pending snapshot.
- R12: After reset every channel has mode 0, binary format and access 01, and no pulse is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel or control register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Byte a read of `addr` returns |
| live_cnt | input | 48 | Running count per channel, channel i at [16i+15:16i] |
| ch_mode | output | 9 | Mode per channel, channel i at [3i+2:3i] |
| ch_bcd | output | 3 | BCD flag per channel |
| ch_mode_set | output | 3 | One-cycle pulse after a control word |
| ch_load | output | 3 | One-cycle pulse when a full count is written |
| ch_load_val | output | 48 | Last assembled count per channel |
| ch_latch_req | output | 3 | One-cycle pulse when a snapshot is taken |

## Verification
The hardest state to reach is a pending snapshot that is half read, with the live count moving underneath it, while a second latch command arrives. The stimulus takes a snapshot on a two-byte channel and reads only the low byte. It then changes the live count and issues another latch command. The remaining read must return the old high byte, and `ch_latch_req` must stay low. A half-written two-byte count that is cut off by a control word is reached the same way, by splitting the byte writes around that control write.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
  parameter int NUM_CH  = 3;
  parameter int BYTE_W  = 8;
  parameter int CNT_W   = 2 * BYTE_W;
  parameter int MODE_W  = 3;
  parameter int ADDR_W  = 2;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_host_pkg::*;
(
  input  logic                cs_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [NUM_CH-1:0]   cnt_wr,
  output logic [NUM_CH-1:0]   cnt_rd,
  output logic [NUM_CH-1:0]   ctl_wr,
  output logic [NUM_CH-1:0]   latch_cmd
);
  localparam logic [ADDR_W-1:0] CTL_ADDR = {ADDR_W{1'b1}};

  logic do_wr, do_rd, ctl_hit;
  logic [1:0] tgt;
  logic [1:0] acc;

  always_comb begin
    do_wr   = !cs_n && !wr_n;
    do_rd   = !cs_n && !rd_n && wr_n;
    ctl_hit = do_wr && (addr == CTL_ADDR);
    tgt     = wdata[7:6];
    acc     = wdata[5:4];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
    always_comb begin
      cnt_wr[g]    = do_wr && (addr == ADDR_W'(g));
      cnt_rd[g]    = do_rd && (addr == ADDR_W'(g));
      ctl_wr[g]    = ctl_hit && (tgt == 2'(g)) && (acc != ACC_LATCH);
      latch_cmd[g] = ctl_hit && (tgt == 2'(g)) && (acc == ACC_LATCH);
    end
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_host_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr,
  input  logic               latch_cmd,
  input  logic               cnt_wr,
  input  logic               cnt_rd,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic [CNT_W-1:0]   live_cnt,
  output logic [MODE_W-1:0]  mode,
  output logic               bcd,
  output logic               mode_set,
  output logic               load,
  output logic [CNT_W-1:0]   load_val,
  output logic               latch_req,
  output logic [BYTE_W-1:0]  rd_byte
);
  acc_e               acc_q, acc_d;
  logic [MODE_W-1:0]  mode_d;
  logic               bcd_d;
  logic               wptr_q, wptr_d;
  logic               rptr_q, rptr_d;
  logic [BYTE_W-1:0]  lo_q, lo_d;
  logic               held_q, held_d;
  logic [CNT_W-1:0]   snap_q, snap_d;
  logic [CNT_W-1:0]   lval_d;
  logic               mset_d, load_d, lreq_d;
  logic [CNT_W-1:0]   src;
  logic               sel_hi;

  always_comb begin
    acc_d  = acc_q;
    mode_d = mode;
    bcd_d  = bcd;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lo_d   = lo_q;
    held_d = held_q;
    snap_d = snap_q;
    lval_d = load_val;
    mset_d = 1'b0;
    load_d = 1'b0;
    lreq_d = 1'b0;
    if (ctl_wr) begin
      acc_d  = acc_e'(wdata[5:4]);
      mode_d = wdata[3:1];
      bcd_d  = wdata[0];
      wptr_d = 1'b0;
      rptr_d = 1'b0;
      held_d = 1'b0;
      mset_d = 1'b1;
    end else if (latch_cmd) begin
      if (!held_q) begin
        snap_d = live_cnt;
        held_d = 1'b1;
        lreq_d = 1'b1;
      end
    end else if (cnt_wr) begin
      unique case (acc_q)
        ACC_HI: begin
          lval_d = {wdata, {BYTE_W{1'b0}}};
          load_d = 1'b1;
        end
        ACC_LOHI: begin
          if (!wptr_q) begin
            lo_d   = wdata;
            wptr_d = 1'b1;
          end else begin
            lval_d = {wdata, lo_q};
            load_d = 1'b1;
            wptr_d = 1'b0;
          end
        end
        default: begin
          lval_d = {{BYTE_W{1'b0}}, wdata};
          load_d = 1'b1;
        end
      endcase
    end else if (cnt_rd) begin
      if (acc_q == ACC_LOHI) begin
        rptr_d = !rptr_q;
        if (rptr_q) held_d = 1'b0;
      end else begin
        held_d = 1'b0;
      end
    end
  end

  always_comb begin
    src     = held_q ? snap_q : live_cnt;
    sel_hi  = (acc_q == ACC_HI) || ((acc_q == ACC_LOHI) && rptr_q);
    rd_byte = sel_hi ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= ACC_LO;
      mode      <= '0;
      bcd       <= 1'b0;
      wptr_q    <= 1'b0;
      rptr_q    <= 1'b0;
      lo_q      <= '0;
      held_q    <= 1'b0;
      snap_q    <= '0;
      load_val  <= '0;
      mode_set  <= 1'b0;
      load      <= 1'b0;
      latch_req <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      mode      <= mode_d;
      bcd       <= bcd_d;
      wptr_q    <= wptr_d;
      rptr_q    <= rptr_d;
      lo_q      <= lo_d;
      held_q    <= held_d;
      snap_q    <= snap_d;
      load_val  <= lval_d;
      mode_set  <= mset_d;
      load      <= load_d;
      latch_req <= lreq_d;
    end
  end
endmodule

// File: rtl/tmr_rdata_mux.sv
module tmr_rdata_mux
  import tmr_host_pkg::*;
(
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_CH*BYTE_W-1:0] ch_byte,
  output logic [BYTE_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr == ADDR_W'(i)) rdata = ch_byte[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_host_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       rd_n,
  input  logic                       wr_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [BYTE_W-1:0]          rdata,
  input  logic [NUM_CH*CNT_W-1:0]    live_cnt,
  output logic [NUM_CH*MODE_W-1:0]   ch_mode,
  output logic [NUM_CH-1:0]          ch_bcd,
  output logic [NUM_CH-1:0]          ch_mode_set,
  output logic [NUM_CH-1:0]          ch_load,
  output logic [NUM_CH*CNT_W-1:0]    ch_load_val,
  output logic [NUM_CH-1:0]          ch_latch_req
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]    rst_pipe;
  logic                      rst_int_n;
  logic [NUM_CH-1:0]         cnt_wr, cnt_rd, ctl_wr, latch_cmd;
  logic [NUM_CH*BYTE_W-1:0]  ch_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  tmr_bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .cnt_wr(cnt_wr), .cnt_rd(cnt_rd), .ctl_wr(ctl_wr), .latch_cmd(latch_cmd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_chan_regs u_ch (
      .clk(clk), .rst_n(rst_int_n),
      .ctl_wr(ctl_wr[g]), .latch_cmd(latch_cmd[g]),
      .cnt_wr(cnt_wr[g]), .cnt_rd(cnt_rd[g]),
      .wdata(wdata),
      .live_cnt(live_cnt[g*CNT_W +: CNT_W]),
      .mode(ch_mode[g*MODE_W +: MODE_W]),
      .bcd(ch_bcd[g]),
      .mode_set(ch_mode_set[g]),
      .load(ch_load[g]),
      .load_val(ch_load_val[g*CNT_W +: CNT_W]),
      .latch_req(ch_latch_req[g]),
      .rd_byte(ch_byte[g*BYTE_W +: BYTE_W])
    );
  end

  tmr_rdata_mux u_mux (.addr(addr), .ch_byte(ch_byte), .rdata(rdata));
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
  import tmr_host_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cs_n,
  input logic                      rd_n,
  input logic                      wr_n,
  input logic [ADDR_W-1:0]         addr,
  input logic [BYTE_W-1:0]         rdata,
  input logic [NUM_CH*MODE_W-1:0]  ch_mode,
  input logic [NUM_CH-1:0]         ch_bcd,
  input logic [NUM_CH-1:0]         ch_mode_set,
  input logic [NUM_CH-1:0]         ch_load,
  input logic [NUM_CH*CNT_W-1:0]   ch_load_val,
  input logic [NUM_CH-1:0]         ch_latch_req
);
  localparam logic [ADDR_W-1:0] CTL = {ADDR_W{1'b1}};

  AST_LOAD_FROM_CNT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load != '0) |-> $past(!cs_n && !wr_n && addr != CTL)); // R1
  AST_CTL_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == CTL) |-> (rdata == '0)); // R1
  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (ch_load == '0 && ch_mode_set == '0 && ch_latch_req == '0)); // R2
  AST_MODESET_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mode_set != '0) |-> $past(!cs_n && !wr_n && addr == CTL)); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_mode_set == '0) |-> ($stable(ch_mode) && $stable(ch_bcd))); // R3
  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load)); // R4
  AST_LATCH_FROM_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_latch_req != '0) |-> $past(!cs_n && !wr_n && addr == CTL)); // R8
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cs_n && !rd_n && wr_n) |->
      (ch_load == '0 && ch_mode_set == '0 && ch_latch_req == '0)); // R10
  AST_LOADVAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_load == '0) |-> $stable(ch_load_val)); // R10
endmodule

bind tmr_host_if tmr_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
  .addr(addr), .rdata(rdata), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
  .ch_mode_set(ch_mode_set), .ch_load(ch_load), .ch_load_val(ch_load_val),
  .ch_latch_req(ch_latch_req)
);

// File: tb/tmr_host_if_bench.sv
module tmr_host_if_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, cs_n, rd_n, wr_n;
  logic [1:0]  addr;
  logic [7:0]  wdata, rdata;
  logic [47:0] live_cnt;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_bcd, ch_mode_set, ch_load, ch_latch_req;
  logic [47:0] ch_load_val;

  tmr_host_if u_tmr_host_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt),
    .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_mode_set(ch_mode_set),
    .ch_load(ch_load), .ch_load_val(ch_load_val), .ch_latch_req(ch_latch_req)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_acc[3], m_mode[3], m_bcd[3], m_wp[3], m_rp[3], m_lo[3];
  int m_held[3], m_snap[3], m_lval[3];
  int e_mset[3], e_load[3], e_lreq[3];
  int live[3];

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = !clk;
  end

  initial begin
    #(CLK_PERIOD*50000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_rd(int a);
    int src, hi;
    if (a == 3) return 0;
    src = m_held[a] ? m_snap[a] : live[a];
    hi  = (m_acc[a] == 2) || (m_acc[a] == 3 && m_rp[a] == 1);
    return hi ? (src >> 8) & 255 : src & 255;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin
      m_acc[i] = 1; m_mode[i] = 0; m_bcd[i] = 0; m_wp[i] = 0; m_rp[i] = 0;
      m_lo[i] = 0; m_held[i] = 0; m_snap[i] = 0; m_lval[i] = 0;
      e_mset[i] = 0; e_load[i] = 0; e_lreq[i] = 0;
    end
  endtask

  task automatic model_step(int cs, int rd, int wr, int a, int d);
    int c, ac;
    for (int i = 0; i < 3; i++) begin e_mset[i] = 0; e_load[i] = 0; e_lreq[i] = 0; end
    if (cs != 0) return;
    if (wr == 0) begin
      if (a == 3) begin
        c = (d >> 6) & 3; ac = (d >> 4) & 3;
        if (c == 3) return;
        if (ac != 0) begin
          m_acc[c] = ac; m_mode[c] = (d >> 1) & 7; m_bcd[c] = d & 1;
          m_wp[c] = 0; m_rp[c] = 0; m_held[c] = 0; e_mset[c] = 1;
        end else if (!m_held[c]) begin
          m_snap[c] = live[c]; m_held[c] = 1; e_lreq[c] = 1;
        end
      end else if (m_acc[a] == 1) begin
        m_lval[a] = d; e_load[a] = 1;
      end else if (m_acc[a] == 2) begin
        m_lval[a] = d << 8; e_load[a] = 1;
      end else if (m_wp[a] == 0) begin
        m_lo[a] = d; m_wp[a] = 1;
      end else begin
        m_lval[a] = (d << 8) | m_lo[a]; e_load[a] = 1; m_wp[a] = 0;
      end
    end else if (rd == 0 && a != 3) begin
      if (m_acc[a] == 3) begin
        if (m_rp[a] == 1) m_held[a] = 0;
        m_rp[a] = 1 - m_rp[a];
      end else m_held[a] = 0;
    end
  endtask

  task automatic compare_outputs(string req);
    for (int i = 0; i < 3; i++) begin
      chk(req, int'(ch_mode[i*3 +: 3]), m_mode[i]);
      chk(req, int'(ch_bcd[i]), m_bcd[i]);
      chk(req, int'(ch_mode_set[i]), e_mset[i]);
      chk(req, int'(ch_load[i]), e_load[i]);
      chk(req, int'(ch_load_val[i*16 +: 16]), m_lval[i]);
      chk(req, int'(ch_latch_req[i]), e_lreq[i]);
    end
  endtask

  // one bus cycle: drive at negedge, check rdata, clock, check registered outputs
  task automatic cyc(string req, int cs, int rd, int wr, int a, int d);
    cs_n = cs[0]; rd_n = rd[0]; wr_n = wr[0]; addr = a[1:0]; wdata = d[7:0];
    live_cnt = {live[2][15:0], live[1][15:0], live[0][15:0]};
    #1;
    chk(req, int'(rdata), exp_rd(a));
    @(posedge clk);
    model_step(cs, rd, wr, a, d);
    @(negedge clk);
    compare_outputs(req);
  endtask

  task automatic wr_b(string req, int a, int d); cyc(req, 0, 1, 0, a, d); endtask
  task automatic rd_b(string req, int a);        cyc(req, 0, 0, 1, a, 0); endtask
  task automatic idle(string req);               cyc(req, 1, 1, 1, 0, 0); endtask

  initial begin
    rst_n = 0; cs_n = 1; rd_n = 1; wr_n = 1; addr = 0; wdata = 0;
    live[0] = 'h1234; live[1] = 'h5678; live[2] = 'hABCD;
    live_cnt = {live[2][15:0], live[1][15:0], live[0][15:0]};
    model_reset();
    repeat (3) @(negedge clk);
    compare_outputs("R12 reset");
    rst_n = 1;
    repeat (4) idle("R12 after reset");
    rd_b("R12 default low byte read", 0);

    // R3 R4: control 0x10 then low byte 200
    wr_b("R3 ctl 0x10", 3, 'h10);
    wr_b("R4 low-only load", 0, 200);
    wr_b("R1 R3 ctl ch1 mode3", 3, 'h56);
    wr_b("R1 R4 ch1 load", 1, 20);
    // R6 two-byte on ch2
    wr_b("R3 ctl 0xB4", 3, 'hB4);
    wr_b("R6 first byte no load", 2, 'hD0);
    wr_b("R6 second byte", 2, 'h07);
    // R5 high only, BCD mode 5 on ch1
    wr_b("R3 R5 ctl 0x6B", 3, 'h6B);
    wr_b("R5 high-only load", 1, 'h99);
    rd_b("R7 high-only read", 1);
    // R2 chip select inactive
    cyc("R2 cs high write", 1, 1, 0, 2, 'h55);
    cyc("R2 cs high ctl", 1, 1, 0, 3, 'h12);
    cyc("R2 cs high read", 1, 0, 1, 2, 0);
    wr_b("R6 after idle first", 2, 'h01);
    wr_b("R6 after idle second", 2, 'h02);
    // R3 channel code 3 ignored
    wr_b("R3 ctl chan 3 ignored", 3, 'hFF);
    // R7 two-byte reads, R10 reads no pulses
    rd_b("R7 R10 read low", 2);
    rd_b("R7 R10 read high", 2);
    rd_b("R7 read low again", 2);
    rd_b("R7 read high again", 2);
    rd_b("R1 control read zero", 3);
    // R8 latch ch2 and move live
    wr_b("R8 latch ch2", 3, 'h80);
    live[2] = 'h1111;
    rd_b("R8 frozen low", 2);
    live[2] = 'h2222;
    rd_b("R8 frozen high", 2);
    rd_b("R8 live low after", 2);
    rd_b("R8 live high after", 2);
    // R9 half-read snapshot, second latch ignored
    live[2] = 'h3C5A;
    wr_b("R8 latch again", 3, 'h80);
    rd_b("R9 read low of snapshot", 2);
    live[2] = 'h7788;
    wr_b("R9 second latch ignored", 3, 'h80);
    rd_b("R9 high still old", 2);
    rd_b("R9 now live low", 2);
    rd_b("R9 now live high", 2);
    // R8 latch on low-only channel 0
    live[0] = 'hBEEF;
    wr_b("R8 latch ch0", 3, 'h00);
    live[0] = 'h0001;
    rd_b("R8 ch0 frozen low", 0);
    rd_b("R8 ch0 live low", 0);
    // R11 control word cuts half-written count and resets read pointer
    wr_b("R11 first byte", 2, 'h11);
    wr_b("R11 ctl mid count", 3, 'hB5);
    wr_b("R11 restart low", 2, 'h22);
    wr_b("R11 high", 2, 'h33);
    rd_b("R11 read low", 2);
    wr_b("R11 ctl mid read", 3, 'hB4);
    rd_b("R11 read restarts low", 2);
    wr_b("R11 latch ch2", 3, 'h80);
    wr_b("R11 ctl drops snapshot", 3, 'hB4);
    live[2] = 'h4455;
    rd_b("R11 live after drop", 2);
    // R2 both strobes low: write only
    cyc("R2 rd and wr low", 0, 0, 0, 0, 'h7E);
    rd_b("R2 ch0 read", 0);
    repeat (2) idle("R10 idle tail");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule